// File: doc/BRIEF.md
# Chunked SPI Data Block Writer

This block streams a host-to-device payload of any length from 5 bytes up to 2^24-1 bytes toward an SPI byte shifter. It cuts the payload into packets of at most `MAX_PKT` bytes, 8192 by default. Each packet opens with a header byte whose upper nibble is all ones. The low two bits of that header tell the receiver where the packet sits in the sequence. When checksums are enabled, two trailer bytes follow the packet's payload. In this scheme those trailer bytes are always zero.

The caller pulses `start` together with the length and the checksum enable. The block then pulls payload bytes from a valid/ready input and pushes the framed stream out through a valid/ready output. It never waits for any reply between packets. The next header goes out as soon as the previous packet's last byte has been accepted. When the final byte is accepted, `done` pulses once. A request that is too short is refused with a one-cycle `rejected` pulse, and nothing is sent.

Top module: `spi_blk_writer`

## Requirements
- R1: After reset the block is idle: `busy`, `out_valid`, `in_ready`, `done` and `rejected` are all 0.
- R2: A `start` whose `total_len` is 4 or less produces `rejected`=1 in the next cycle. No byte is emitted and `busy` stays 0.
- R3: The header byte is 0xF0 with the order code in bits 1:0. The code is 3 whenever the remaining count is at most `MAX_PKT`, whether the packet is the first one or a later one.
- R4: The first packet of a transfer longer than `MAX_PKT` has order code 1 (header 0xF1).
- R5: Every packet that is neither first nor able to finish the transfer has order code 2 (header 0xF2).
- R6: Each packet carries the smaller of the remaining count and `MAX_PKT` payload bytes. These are copied from `in_data` in arrival order, unchanged.
- R7: With `crc_en`=1 at start, two 0x00 bytes follow every packet's payload. With `crc_en`=0, no trailer bytes are sent.
- R8: The next header is offered in the cycle after the previous packet's last byte is accepted. After the transfer's final byte is accepted, `done`=1 for exactly one cycle and `busy` returns to 0.
- R9: While the payload input has no valid byte, `out_valid` stays low; no filler byte is ever inserted. While `out_ready` is low, an offered byte is held stable.
- R10: `total_len` and `crc_en` are captured at `start`. Changing them during a transfer has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| total_len | input | 24 | Payload byte count |
| crc_en | input | 1 | Append two zero trailer bytes per packet |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken |
| out_valid | output | 1 | Output byte offered |
| out_data | output | 8 | Output byte to the shifter |
| out_ready | input | 1 | Shifter accepts byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| rejected | output | 1 | One-cycle pulse for a too-short request |

## Verification
The bench reduces the packet size to 8 so it can cover the awkward lengths. A length of exactly one packet must use code 3 and never code 1. One byte beyond a packet must give a 1-byte final packet. Long transfers need several middle packets. A design that chose the code from the packet index alone would send 0xF1 on a single full packet. A design with an off-by-one in the split would put the wrong number of bytes between headers or drop the last byte. Random stalls on both sides catch filler bytes and dropped bytes. A change of length in mid-transfer catches a design that reads `total_len` live. Lengths 4 and 0 must be refused with no output at all.

// File: rtl/spi_blk_writer.sv
module spi_blk_writer #(
  parameter int LEN_W   = 24,
  parameter int MAX_PKT = 8192,
  parameter int MIN_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic             crc_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             busy,
  output logic             done,
  output logic             rejected
);
  localparam int PW = $clog2(MAX_PKT + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_CRC0, S_CRC1} st_t;

  st_t              st;
  logic [LEN_W-1:0] rem;
  logic [PW-1:0]    pkt_left;
  logic             first, crc_q, done_q, rej_q;

  wire       fits  = rem <= LEN_W'(MAX_PKT);
  wire [1:0] order = fits ? 2'b11 : (first ? 2'b01 : 2'b10);
  wire       fire  = out_valid && out_ready;

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign rejected  = rej_q;
  assign in_ready  = (st == S_DATA) && out_ready;
  assign out_valid = (st == S_HDR) || (st == S_CRC0) || (st == S_CRC1) ||
                     ((st == S_DATA) && in_valid);
  assign out_data  = (st == S_HDR)  ? {6'b111100, order} :
                     (st == S_DATA) ? in_data : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rem      <= '0;
      pkt_left <= '0;
      first    <= 1'b0;
      crc_q    <= 1'b0;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (total_len < LEN_W'(MIN_LEN)) rej_q <= 1'b1;
          else begin
            rem   <= total_len;
            crc_q <= crc_en;
            first <= 1'b1;
            st    <= S_HDR;
          end
        end
        S_HDR: if (fire) begin
          pkt_left <= fits ? PW'(rem) : PW'(MAX_PKT);
          first    <= 1'b0;
          st       <= S_DATA;
        end
        S_DATA: if (fire) begin
          rem      <= rem - 1'b1;
          pkt_left <= pkt_left - 1'b1;
          if (pkt_left == PW'(1)) begin
            if (crc_q) st <= S_CRC0;
            else if (rem == LEN_W'(1)) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else st <= S_HDR;
          end
        end
        S_CRC0: if (fire) st <= S_CRC1;
        S_CRC1: if (fire) begin
          if (rem == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else st <= S_HDR;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !in_ready);

  assert_short_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && total_len < LEN_W'(MIN_LEN)) |=> rejected && !busy);

  assert_pkt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_left <= PW'(MAX_PKT));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && st != S_DATA) |=> out_valid && $stable(out_data));

  assert_rem_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> $stable(rem));

  assert_end_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rejected && rem == '0);
endmodule

// File: tb/spi_blk_writer_tb.sv
module spi_blk_writer_tb;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] total_len = '0;
  logic crc_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic [7:0] out_data;
  logic out_ready = 1'b0;
  logic busy, done, rejected;

  int checks = 0, fails = 0, cycles = 0;
  int pay_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] exp_q[$];
  int tag_q[$];

  always #5 clk = ~clk;

  spi_blk_writer #(.LEN_W(24), .MAX_PKT(MAXP), .MIN_LEN(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len), .crc_en(crc_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done(done), .rejected(rejected));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Reference model: the full expected stream for one transfer (R3..R7)
  task automatic build_exp(input int len, input bit crc);
    int r = len, idx = 0;
    bit first = 1;
    exp_q.delete();
    tag_q.delete();
    while (r > 0) begin
      int n = (r < MAXP) ? r : MAXP;
      if (r <= MAXP) begin exp_q.push_back(8'hF3); tag_q.push_back(3); end
      else if (first) begin exp_q.push_back(8'hF1); tag_q.push_back(4); end
      else begin exp_q.push_back(8'hF2); tag_q.push_back(5); end
      for (int i = 0; i < n; i++) begin
        exp_q.push_back(8'((idx ^ 8'h5A) & 8'hFF));
        tag_q.push_back(6);
        idx++;
      end
      if (crc) for (int i = 0; i < 2; i++) begin exp_q.push_back(8'h00); tag_q.push_back(7); end
      r -= n;
      first = 0;
    end
  endtask

  task automatic run(input int len, input bit crc, input bit stall, input bit change);
    bit fin = 0;
    int gap = 0;
    int prev_tag = 0;
    bit gap_seen = 0;
    build_exp(len, crc);
    pay_cnt = 0;
    @(negedge clk);
    start = 1'b1; total_len = 24'(len); crc_en = crc;
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (change) begin total_len = 24'd3; crc_en = ~crc; end  // R10: must be ignored
    while (!fin) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = stall ? lfsr[0] : 1'b1;
      out_ready = stall ? (lfsr[3] | lfsr[5]) : 1'b1;
      in_data   = 8'((pay_cnt ^ 8'h5A) & 8'hFF);
      #2;
      if (done) begin
        chk(exp_q.size() == 0, "R8 done after last byte", exp_q.size(), 0);
        chk(!busy, "R8 busy drop", busy, 0);
        fin = 1;
      end else begin
        // R9: no filler while payload source is empty
        if (exp_q.size() > 0 && tag_q[0] == 6 && !in_valid)
          chk(!out_valid, "R9 filler", out_valid, 0);
        // R8: header follows previous packet with no idle gap when ready is held high
        if (!stall && exp_q.size() > 0 && prev_tag != 0 && tag_q[0] != prev_tag && !out_valid)
          gap_seen = 1;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(0, "R6 extra byte", out_data, 0);
          else begin
            string t;
            t = $sformatf("R%0d byte", tag_q[0]);
            chk(out_data == exp_q[0], t, out_data, exp_q[0]);
            prev_tag = tag_q[0];
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end
        end
        if (in_valid && in_ready) pay_cnt++;
        gap++;
        if (gap > 5000) begin chk(0, "R8 transfer hang", gap, 0); fin = 1; end
      end
    end
    if (!stall) chk(!gap_seen, "R8 no gap between packets", gap_seen, 0);
  endtask

  task automatic refuse(input int len);
    @(negedge clk);
    start = 1'b1; total_len = 24'(len); crc_en = 1'b1;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #2;
    chk(rejected, "R2 rejected pulse", rejected, 1);
    chk(!busy, "R2 busy", busy, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      chk(!out_valid && !busy, "R2 no output", out_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !out_valid && !in_ready && !done && !rejected, "R1 reset state",
        {busy, out_valid, in_ready, done, rejected}, 0);
    rst_n = 1'b1;
    refuse(4);              // R2
    refuse(0);              // R2
    run(5, 1, 0, 0);        // R3 R7 single packet
    run(8, 1, 0, 0);        // R3 exactly one packet -> code 3
    run(9, 0, 0, 0);        // R4 then 1-byte last packet, R7 off
    run(20, 1, 0, 0);       // R4 R5 R3
    run(41, 0, 1, 0);       // R5 R9 stalls on both sides
    run(33, 1, 1, 0);       // R7 R9
    run(24, 1, 0, 1);       // R10 length change mid-transfer
    run(17, 0, 1, 1);       // R10 with stalls
    @(negedge clk); #2;
    chk(!busy && !out_valid, "R1 idle after runs", busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule